// File: doc/BRIEF.md
# I2C SCL Timing Divider

This block turns an 8-bit divider code into the bit timing an I2C master needs. The code is not a plain count. It is split into two table indices. A base index selects a pair of constants: a fixed offset and a per-tap step. A tap index selects an SCL tap multiplier and an SDA tap multiplier. From these the block computes the full SCL period and the SDA hold delay, both counted in input-clock cycles.

While enabled, a counter runs through one SCL period after another. The block drives an SCL level that is low for the first half of each period and high for the second half. It also gives a one-cycle strobe at each SCL edge, and a one-cycle SDA-change strobe placed the hold delay after each falling edge. A byte engine would use these strobes to shift data onto the bus.

A new code written while the divider runs is taken up only at the next period boundary, so a period in progress is never cut short. While the block is disabled, its counter stays at zero.

Top module: `i2c_scl_divider`

## Requirements
- R1: The base index is code bits 4:2. The tap index is code bit 5 as its upper bit, with code bits 1:0 below it. Code bits 7:6 have no effect on any output.
- R2: The base pairs (offset, step) for base index 0..7 are (4,1), (4,2), (6,4), (6,8), (14,16), (30,32), (62,64), (126,128). The SCL taps for tap index 0..7 are 9, 10, 12, 15, 5, 6, 7, 8. `sclPeriod` equals 2*(offset + (scltap-1)*step + 2).
- R3: The SDA taps for tap index 0..7 are 3, 3, 4, 4, 1, 1, 2, 2. `sdaHold` equals offset + (sdatap-1)*step + 3.
- R4: Each period starts in the cycle after the previous one ends, at counter position 0. `sclOut` is 0 from position 0 up to, but not including, half the period, and 1 for the rest of the period. `sclEdgeStb` is 1 for exactly one cycle at position 0 and for one cycle at the half-period position.
- R5: `sdaChgStb` is 1 for exactly one cycle in each period, at position `sdaHold`, which always falls inside the low half.
- R6: `sclPeriod` and `sdaHold` describe the active code. While enabled, a change to `divCode` becomes the active code only after the last cycle of the current period. The period in progress completes with the old timing.
- R7: While `enable` is 0, the counter is held at zero, `sclOut` is 1, both strobes are 0, and the active code takes the value of `divCode` at each clock edge. The first cycle with `enable` at 1 is position 0 of a new period, with a falling-edge strobe.
- R8: During reset (`rstN` at 0, asynchronous), the active code is 0. This gives `sclPeriod` 28 and `sdaHold` 9. `sclOut` is 1 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all timing is counted in its cycles |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the SCL period counter when 1 |
| divCode | input | 8 | Divider code |
| sclPeriod | output | 12 | Full SCL period of the active code, in clock cycles |
| sdaHold | output | 12 | SDA hold delay of the active code, in clock cycles |
| sclOut | output | 1 | SCL level: 0 in the low half, 1 in the high half or when idle |
| sclEdgeStb | output | 1 | One-cycle strobe at each SCL falling and rising edge |
| sdaChgStb | output | 1 | One-cycle strobe at the point where SDA may change |

## Verification
The bench sweeps all 64 pairs of base index and tap index with the block disabled, and compares both computed values against its own table model. A swapped bit in the tap-index decode, or a wrong table entry, therefore shows up as a wrong period or hold value for at least one pair. Cycle-by-cycle runs at several codes check the position of each strobe and the exact cycle where SCL rises. An off-by-one in the wrap or in the half-period compare would make periods one cycle too long, or move the rising edge by one cycle.

Two further tests go after timing corner cases. One changes the code in the middle of a period: a design that loads the new code at once would cut the running period short. The other drops and restores the enable in the middle of a period: a design that does not clear its counter would resume at the old position instead of restarting with a falling edge. Codes that differ only in bits 7:6 must give the same timing.

// File: rtl/i2cdiv_pkg.sv
package i2cdiv_pkg;

  // Control from the sequencer to the datapath
  typedef struct packed {
    logic clrCnt;    // hold counter at zero
    logic wrapCnt;   // restart period at next edge
    logic loadCode;  // capture divider code into active register
  } dpCtl_t;

  // Position flags reported by the datapath
  typedef struct packed {
    logic atZero;
    logic atHalf;
    logic atHold;
    logic atWrap;
  } dpFlags_t;

  // Fixed offset of each base pair
  function automatic logic [7:0] baseOffset(input logic [2:0] idx);
    case (idx)
      3'd0, 3'd1: baseOffset = 8'd4;
      3'd2, 3'd3: baseOffset = 8'd6;
      3'd4:       baseOffset = 8'd14;
      3'd5:       baseOffset = 8'd30;
      3'd6:       baseOffset = 8'd62;
      default:    baseOffset = 8'd126;
    endcase
  endfunction

  // Per-tap step of each base pair: a power of two
  function automatic logic [7:0] baseStep(input logic [2:0] idx);
    baseStep = 8'd1 << idx;
  endfunction

  function automatic logic [3:0] sclTap(input logic [2:0] idx);
    case (idx)
      3'd0:    sclTap = 4'd9;
      3'd1:    sclTap = 4'd10;
      3'd2:    sclTap = 4'd12;
      3'd3:    sclTap = 4'd15;
      3'd4:    sclTap = 4'd5;
      3'd5:    sclTap = 4'd6;
      3'd6:    sclTap = 4'd7;
      default: sclTap = 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] sdaTap(input logic [2:0] idx);
    case (idx)
      3'd0, 3'd1: sdaTap = 4'd3;
      3'd2, 3'd3: sdaTap = 4'd4;
      3'd4, 3'd5: sdaTap = 4'd1;
      default:    sdaTap = 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/i2cdiv_datapath.sv
module i2cdiv_datapath
  import i2cdiv_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [CODE_W-1:0] divCode,
  output dpFlags_t          flags,
  output logic [CNT_W-1:0]  sclPeriod,
  output logic [CNT_W-1:0]  sdaHold
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CODE_W-1:0] actCode;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        baseIdx;
  logic [2:0]        tapIdx;
  logic [CNT_W-1:0]  offW, stepW, sclTapW, sdaTapW, halfTicks;

  // Active code register: only written when the sequencer allows it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             actCode <= '0;
    else if (ctl.loadCode) actCode <= divCode;
  end

  // Scattered decode of the active code
  assign baseIdx = actCode[4:2];
  assign tapIdx  = {actCode[5], actCode[1:0]};

  always_comb begin
    offW      = CNT_W'(baseOffset(baseIdx));
    stepW     = CNT_W'(baseStep(baseIdx));
    sclTapW   = CNT_W'(sclTap(tapIdx));
    sdaTapW   = CNT_W'(sdaTap(tapIdx));
    halfTicks = offW + (sclTapW - ONE) * stepW + CNT_W'(2);
    sclPeriod = halfTicks << 1;
    sdaHold   = offW + (sdaTapW - ONE) * stepW + CNT_W'(3);
  end

  // Period position counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         cnt <= '0;
    else if (ctl.clrCnt || ctl.wrapCnt) cnt <= '0;
    else                                cnt <= cnt + ONE;
  end

  always_comb begin
    flags.atZero = (cnt == '0);
    flags.atHalf = (cnt == halfTicks);
    flags.atHold = (cnt == sdaHold);
    flags.atWrap = (cnt == sclPeriod - ONE);
  end

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clrCnt && !ctl.wrapCnt) |=> (cnt == $past(cnt) + ONE));

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt < sclPeriod);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrCnt |=> (cnt == '0));

  p_code_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadCode |=> $stable(actCode));

endmodule

// File: rtl/i2cdiv_ctrl.sv
module i2cdiv_ctrl
  import i2cdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  dpFlags_t flags,
  output dpCtl_t   ctl,
  output logic     sclOut,
  output logic     sclEdgeStb,
  output logic     sdaChgStb
);

  logic highPhase;

  always_comb begin
    ctl.clrCnt   = !enable;
    ctl.wrapCnt  = enable && flags.atWrap;
    ctl.loadCode = !enable || flags.atWrap;
  end

  // Remembers that the high half has started in this period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              highPhase <= 1'b0;
    else if (!enable)       highPhase <= 1'b0;
    else if (flags.atWrap)  highPhase <= 1'b0;
    else if (flags.atHalf)  highPhase <= 1'b1;
  end

  assign sclOut     = !enable || highPhase || flags.atHalf;
  assign sclEdgeStb = enable && (flags.atZero || flags.atHalf);
  assign sdaChgStb  = enable && flags.atHold;

  p_sda_low_half_r5: assert property (@(posedge clk) disable iff (!rstN)
    sdaChgStb |-> !sclOut);

  p_fall_strobed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && $fell(sclOut)) |-> sclEdgeStb);

  p_rise_strobed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $rose(sclOut)) |-> sclEdgeStb);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($past(enable) || (!sclEdgeStb && !sdaChgStb) || enable));

endmodule

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider
  import i2cdiv_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CODE_W-1:0] divCode,
  output logic [CNT_W-1:0]  sclPeriod,
  output logic [CNT_W-1:0]  sdaHold,
  output logic              sclOut,
  output logic              sclEdgeStb,
  output logic              sdaChgStb
);

  dpCtl_t   ctl;
  dpFlags_t flags;

  i2cdiv_datapath #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .divCode(divCode),
    .flags(flags), .sclPeriod(sclPeriod), .sdaHold(sdaHold)
  );

  i2cdiv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .flags(flags), .ctl(ctl),
    .sclOut(sclOut), .sclEdgeStb(sclEdgeStb), .sdaChgStb(sdaChgStb)
  );

  p_reset_idle_r8: assert property (@(posedge clk) !rstN |-> (sclOut && !sclEdgeStb && !sdaChgStb));

endmodule

// File: tb/tb_i2c_scl_divider.sv
module tb_i2c_scl_divider;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  divCode = 8'hFF;
  logic [11:0] sclPeriod, sdaHold;
  logic        sclOut, sclEdgeStb, sdaChgStb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_scl_divider dut (
    .clk(clk), .rstN(rstN), .enable(enable), .divCode(divCode),
    .sclPeriod(sclPeriod), .sdaHold(sdaHold),
    .sclOut(sclOut), .sclEdgeStb(sclEdgeStb), .sdaChgStb(sdaChgStb)
  );

  // Reference tables taken from the requirements
  function automatic int mOff(input int b);
    int t[8] = '{4, 4, 6, 6, 14, 30, 62, 126};
    return t[b];
  endfunction
  function automatic int mStep(input int b);
    int t[8] = '{1, 2, 4, 8, 16, 32, 64, 128};
    return t[b];
  endfunction
  function automatic int mScl(input int i);
    int t[8] = '{9, 10, 12, 15, 5, 6, 7, 8};
    return t[i];
  endfunction
  function automatic int mSda(input int i);
    int t[8] = '{3, 3, 4, 4, 1, 1, 2, 2};
    return t[i];
  endfunction
  function automatic int mBase(input int c);
    return (c >> 2) & 7;
  endfunction
  function automatic int mTap(input int c);
    return (((c >> 5) & 1) << 2) | (c & 3);
  endfunction
  function automatic int mPeriod(input int c);
    return 2 * (mOff(mBase(c)) + (mScl(mTap(c)) - 1) * mStep(mBase(c)) + 2);
  endfunction
  function automatic int mHold(input int c);
    return mOff(mBase(c)) + (mSda(mTap(c)) - 1) * mStep(mBase(c)) + 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected {sclOut, sclEdgeStb, sdaChgStb} at position k of a period
  function automatic int expVec(input int k, input int p, input int h);
    int pos = k % p;
    int hf = p / 2;
    return ((pos >= hf) ? 4 : 0) | ((pos == 0 || pos == hf) ? 2 : 0) | ((pos == h) ? 1 : 0);
  endfunction

  function automatic int outVec();
    return {29'd0, sclOut, sclEdgeStb, sdaChgStb};
  endfunction

  task automatic testReset();
    #1;
    check(sclPeriod == 12'd28, "R8 period", sclPeriod, 28);
    check(sdaHold == 12'd9, "R8 hold", sdaHold, 9);
    check(outVec() == 4, "R8 outputs", outVec(), 4);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic loadIdle(input int c);
    @(negedge clk);
    enable = 1'b0;
    divCode = 8'(c);
    @(negedge clk);
    #1;
  endtask

  task automatic testSweep();
    for (int b = 0; b < 8; b++) begin
      for (int t = 0; t < 8; t++) begin
        int c = (((t >> 2) & 1) << 5) | (b << 2) | (t & 3);
        loadIdle(c);
        check(int'(sclPeriod) == mPeriod(c), "R2 period sweep", sclPeriod, mPeriod(c));
        check(int'(sdaHold) == mHold(c), "R3 hold sweep", sdaHold, mHold(c));
        check(outVec() == 4, "R7 idle outputs", outVec(), 4);
      end
    end
  endtask

  task automatic testIgnoredBits();
    int codes[4] = '{8'h00, 8'h17, 8'h2A, 8'h3F};
    foreach (codes[i]) begin
      for (int hi = 1; hi < 4; hi++) begin
        int c = codes[i] | (hi << 6);
        loadIdle(c);
        check(int'(sclPeriod) == mPeriod(codes[i]), "R1 bits 7:6 period", sclPeriod, mPeriod(codes[i]));
        check(int'(sdaHold) == mHold(codes[i]), "R1 bits 7:6 hold", sdaHold, mHold(codes[i]));
      end
    end
  endtask

  task automatic testTiming(input int c);
    int p = mPeriod(c & 8'h3F);
    int h = mHold(c & 8'h3F);
    loadIdle(c);
    enable = 1'b1;
    for (int k = 0; k <= 2 * p; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      check(outVec() == expVec(k, p, h), "R4/R5 timing", outVec(), expVec(k, p, h));
    end
    enable = 1'b0;
  endtask

  task automatic testCodeChange();
    int pa = mPeriod(8'h00), ha = mHold(8'h00);
    int pb = mPeriod(8'h04), hb = mHold(8'h04);
    loadIdle(8'h00);
    enable = 1'b1;
    for (int k = 0; k <= pa + pb; k++) begin
      int e;
      if (k > 0) @(negedge clk);
      if (k == 5) divCode = 8'h04;
      #1;
      e = (k < pa) ? expVec(k, pa, ha) : expVec(k - pa, pb, hb);
      check(outVec() == e, "R6 boundary timing", outVec(), e);
      check(int'(sclPeriod) == ((k < pa) ? pa : pb), "R6 active period", sclPeriod, (k < pa) ? pa : pb);
    end
    enable = 1'b0;
  endtask

  task automatic testDisable();
    int p = mPeriod(8'h10), h = mHold(8'h10);
    loadIdle(8'h10);
    enable = 1'b1;
    repeat (p - 3) @(negedge clk);
    enable = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(outVec() == 4, "R7 disabled outputs", outVec(), 4);
      @(negedge clk);
    end
    enable = 1'b1;
    for (int k = 0; k <= p; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      check(outVec() == expVec(k, p, h), "R7 restart timing", outVec(), expVec(k, p, h));
    end
    enable = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testSweep();
    testIgnoredBits();
    testTiming(8'h00);
    testTiming(8'h04);
    testTiming(8'h30);
    testTiming(8'hC4);
    testCodeChange();
    testDisable();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule